// File: doc/BRIEF.md
# Converter Serial Port Host

This block is the host-side master for the serial port of a sigma-delta converter. It produces the serial clock, which rests high between transfers. It drives chip select from one host control bit, or holds it low for three-wire use. It carries out three kinds of command: register writes, data reads, and data-ready polls. A poll reads the communications register, and the result is taken from that register's top bit, so no ready pin is needed. A command is one command byte followed by a count of 1 to 3 data bytes.

Two wiring modes are available. In separate-line mode, data out and data in run on their own pins. In shared-line mode, one pulled-up line carries both directions. The host releases its output enable whenever it receives and whenever it is idle. A recovery command brings a lost port back to a known state. In separate-line mode it sends a run of ones. In shared-line mode it first performs a read and then sends the run of ones. After recovery the block raises a flag saying every converter register must be programmed again.

The half period of the serial clock is programmable. When the converter's output-update moment arrives while a read or poll is still in flight, the host reports a late read.

Top module: `conv_host`

## Requirements
- R1: `sclk` is high whenever `busy` is low. `sdo` changes only on a falling `sclk` edge, and `sdi` is sampled on the rising edge. Each low half period and each high half period lasts `div_half`+1 clock cycles; `div_half` is captured when the command is accepted.
- R2: Opcode 0 (write) sends `cmd_byte` followed by the low N bytes of `wr_data`, each MSB first. N is `cmd_len`, and a value of 0 is treated as 1.
- R3: Opcode 1 (read) sends `cmd_byte` and then clocks in 8·N bits, which appear right-justified in `rd_data` together with the `done` pulse. `sdo` is 1 throughout the input bits.
- R4: Opcode 2 (poll) sends `cmd_byte` and reads exactly one byte, whatever `cmd_len` is. `conv_ready` becomes the inverse of bit 7 of that byte, and the byte is also placed in `rd_data`.
- R5: With `shared_line` = 1 captured at accept, `sdo_oe` is 0 during every input bit and while idle, and 1 during output bits. With `shared_line` = 0, `sdo_oe` stays 1.
- R6: Opcode 3 (recovery) in separate-line mode gives exactly 32 serial clocks with `sdo` at 1.
- R7: Opcode 3 in shared-line mode gives 24 input clocks with `sdo_oe` at 0, then 32 clocks driving 1 with `sdo_oe` at 1.
- R8: `reconfig_req` rises together with the `done` of a recovery. It stays set through reads and polls, and it clears when a write command is accepted.
- R9: `cs_n` follows the inverse of `cs_sel` one cycle later. While `cs_tied` is 1, `cs_n` is 0 from the next cycle on.
- R10: `late_read` pulses one cycle after `upd_tick` is high while a read or poll is busy. It stays 0 for a tick during idle or during a write.
- R11: A command is accepted only while `busy` is 0. `done` is a one-cycle pulse issued with the last rising `sclk`, and `busy` falls in the same cycle. A `cmd_valid` raised while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 write, 1 read, 2 poll, 3 recovery |
| cmd_byte | input | 8 | Command byte sent first |
| cmd_len | input | NBW | Data byte count (0 treated as 1) |
| wr_data | input | 8·MAXB | Write bytes, right-justified |
| div_half | input | DIVW | Half-period length minus one, in clock cycles |
| shared_line | input | 1 | 1 selects single bidirectional data line |
| cs_tied | input | 1 | 1 holds chip select low permanently |
| cs_sel | input | 1 | Host control bit for chip select |
| upd_tick | input | 1 | Converter output-update moment |
| sdi | input | 1 | Serial data from converter (or shared line) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rd_data | output | 8·MAXB | Bytes read, right-justified |
| conv_ready | output | 1 | Result of last poll |
| reconfig_req | output | 1 | Registers must be reprogrammed |
| late_read | output | 1 | Read overlapped an output update |
| sclk | output | 1 | Serial clock, high at rest |
| cs_n | output | 1 | Chip select, active low |
| sdo | output | 1 | Serial data to converter |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The bench builds the block with a 4-bit `div_half` and keeps the 3-byte maximum and the 24/32-clock recovery lengths. Because the divider is narrow, it can sweep half periods of one to four cycles and still fit the full 56-clock shared recovery into a short run. A bus model in the bench records every bit on the line at the rising edges and drives the converter's reply from the ninth clock on. This lets it compare whole bit streams, enable-low counts and half-period lengths across both wiring modes and all four opcodes.

// File: rtl/conv_host_pkg.sv
package conv_host_pkg;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_READ    = 2'd1,
        OP_POLL    = 2'd2,
        OP_RECOVER = 2'd3
    } host_op_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CMD   = 3'd1,
        PH_WDATA = 3'd2,
        PH_RDATA = 3'd3,
        PH_RREAD = 3'd4,
        PH_RONES = 3'd5
    } host_phase_e;

endpackage

// File: rtl/conv_host_clkdiv.sv
module conv_host_clkdiv #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] half_len,
    output logic            tick
);

    logic [DIVW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == half_len);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/conv_host_txsr.sv
module conv_host_txsr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         park,
    output logic         bit_o
);

    logic [W-1:0] sh_d, sh_q;
    logic         out_d, out_q;

    always_comb begin
        sh_d  = sh_q;
        out_d = out_q;
        if (load) begin
            sh_d = load_val;
        end else if (shift) begin
            out_d = sh_q[W-1];
            sh_d  = {sh_q[W-2:0], 1'b1};
        end
        if (park) out_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '1;
            out_q <= 1'b1;
        end else begin
            sh_q  <= sh_d;
            out_q <= out_d;
        end
    end

    assign bit_o = out_q;

endmodule

// File: rtl/conv_host_rxsr.sv
module conv_host_rxsr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] nxt
);

    logic [W-2:0] sh_d, sh_q;

    always_comb begin
        nxt  = {sh_q, din};
        sh_d = sh_q;
        if (clr)        sh_d = '0;
        else if (shift) sh_d = nxt[W-2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/conv_host.sv
module conv_host
    import conv_host_pkg::*;
#(
    parameter int DIVW       = 8,
    parameter int BYTEW      = 8,
    parameter int MAXB       = 3,
    parameter int RECOV_READ = 24,
    parameter int RECOV_ONES = 32,
    localparam int DATAW     = BYTEW * MAXB,
    localparam int NBW       = $clog2(MAXB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [BYTEW-1:0] cmd_byte,
    input  logic [NBW-1:0]   cmd_len,
    input  logic [DATAW-1:0] wr_data,
    input  logic [DIVW-1:0]  div_half,
    input  logic             shared_line,
    input  logic             cs_tied,
    input  logic             cs_sel,
    input  logic             upd_tick,
    input  logic             sdi,
    output logic             busy,
    output logic             done,
    output logic [DATAW-1:0] rd_data,
    output logic             conv_ready,
    output logic             reconfig_req,
    output logic             late_read,
    output logic             sclk,
    output logic             cs_n,
    output logic             sdo,
    output logic             sdo_oe
);

    localparam int LEN_A  = (RECOV_ONES > DATAW) ? RECOV_ONES : DATAW;
    localparam int MAXLEN = (RECOV_READ > LEN_A) ? RECOV_READ : LEN_A;
    localparam int CNTW   = $clog2(MAXLEN + 1);
    localparam int TXW    = (DATAW > BYTEW) ? DATAW : BYTEW + 1;

    typedef struct packed {
        host_phase_e      ph;
        host_op_e         op;
        logic [NBW-1:0]   nby;
        logic             shared;
        logic [DIVW-1:0]  div;
        logic [DATAW-1:0] wdata;
        logic             sclk;
        logic [CNTW-1:0]  cnt;
        logic             done;
        logic [DATAW-1:0] rd;
        logic             ready;
        logic             reconfig;
        logic             late;
        logic             cs_n;
    } host_state_t;

    host_state_t d, q;

    logic             tick;
    logic             tx_load, tx_shift, tx_park;
    logic [TXW-1:0]   tx_val;
    logic             rx_clr, rx_shift;
    logic [DATAW-1:0] rx_nxt;
    logic [CNTW-1:0]  len_m1;
    logic [NBW-1:0]   n_acc;
    logic             is_read_op;
    logic             shared_mode;

    conv_host_clkdiv #(.DIVW(DIVW)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.ph != PH_IDLE),
        .half_len (q.div),
        .tick     (tick)
    );

    conv_host_txsr #(.W(TXW)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (tx_val),
        .shift    (tx_shift),
        .park     (tx_park),
        .bit_o    (sdo)
    );

    conv_host_rxsr #(.W(DATAW)) i_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .shift (rx_shift),
        .din   (sdi),
        .nxt   (rx_nxt)
    );

    // Effective byte count at accept: zero means one, polls always one.
    always_comb begin
        if (cmd_op == OP_POLL || cmd_len == '0)  n_acc = NBW'(1);
        else if (int'(cmd_len) > MAXB)           n_acc = NBW'(MAXB);
        else                                     n_acc = cmd_len;
    end

    // Number of serial clocks in the current phase, minus one.
    always_comb begin
        case (q.ph)
            PH_CMD:             len_m1 = CNTW'(BYTEW - 1);
            PH_WDATA, PH_RDATA: len_m1 = CNTW'(BYTEW * int'(q.nby) - 1);
            PH_RREAD:           len_m1 = CNTW'(RECOV_READ - 1);
            PH_RONES:           len_m1 = CNTW'(RECOV_ONES - 1);
            default:            len_m1 = '0;
        endcase
    end

    assign is_read_op = (q.op == OP_READ) || (q.op == OP_POLL);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.late   = upd_tick && (q.ph != PH_IDLE) && is_read_op;
        d.cs_n   = cs_tied ? 1'b0 : !cs_sel;
        tx_load  = 1'b0;
        tx_val   = '1;
        tx_shift = 1'b0;
        tx_park  = 1'b0;
        rx_clr   = 1'b0;
        rx_shift = 1'b0;

        if (q.ph == PH_IDLE) begin
            if (cmd_valid) begin
                d.op     = host_op_e'(cmd_op);
                d.nby    = n_acc;
                d.shared = shared_line;
                d.div    = div_half;
                d.wdata  = wr_data;
                d.cnt    = '0;
                if (host_op_e'(cmd_op) == OP_RECOVER) begin
                    if (shared_line) begin
                        d.ph   = PH_RREAD;
                        rx_clr = 1'b1;
                    end else begin
                        d.ph   = PH_RONES;
                    end
                    tx_load = 1'b1;
                end else begin
                    d.ph    = PH_CMD;
                    tx_load = 1'b1;
                    tx_val  = {cmd_byte, {(TXW-BYTEW){1'b1}}};
                    if (host_op_e'(cmd_op) == OP_WRITE) d.reconfig = 1'b0;
                end
            end
        end else if (tick) begin
            if (q.sclk) begin
                d.sclk   = 1'b0;
                tx_shift = 1'b1;
            end else begin
                d.sclk   = 1'b1;
                rx_shift = (q.ph == PH_RDATA) || (q.ph == PH_RREAD);
                d.cnt    = q.cnt + 1'b1;
                if (q.cnt == len_m1) begin
                    d.cnt = '0;
                    case (q.ph)
                        PH_CMD: begin
                            tx_load = 1'b1;
                            if (q.op == OP_WRITE) begin
                                d.ph   = PH_WDATA;
                                tx_val = TXW'(q.wdata) << (TXW - BYTEW * int'(q.nby));
                            end else begin
                                d.ph   = PH_RDATA;
                                rx_clr = 1'b1;
                            end
                        end
                        PH_RREAD: begin
                            d.ph    = PH_RONES;
                            tx_load = 1'b1;
                        end
                        PH_RDATA: begin
                            d.ph   = PH_IDLE;
                            d.done = 1'b1;
                            d.rd   = rx_nxt;
                            if (q.op == OP_POLL) d.ready = !rx_nxt[BYTEW-1];
                            tx_park = 1'b1;
                        end
                        PH_RONES: begin
                            d.ph       = PH_IDLE;
                            d.done     = 1'b1;
                            d.reconfig = 1'b1;
                            tx_park    = 1'b1;
                        end
                        default: begin
                            d.ph    = PH_IDLE;
                            d.done  = 1'b1;
                            tx_park = 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.ph       <= PH_IDLE;
            q.op       <= OP_WRITE;
            q.sclk     <= 1'b1;
            q.cs_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign shared_mode  = q.shared;
    assign busy         = (q.ph != PH_IDLE);
    assign done         = q.done;
    assign rd_data      = q.rd;
    assign conv_ready   = q.ready;
    assign reconfig_req = q.reconfig;
    assign late_read    = q.late;
    assign sclk         = q.sclk;
    assign cs_n         = q.cs_n;
    assign sdo_oe       = !q.shared || (q.ph == PH_CMD) || (q.ph == PH_WDATA) ||
                          (q.ph == PH_RONES);

endmodule

// File: rtl/conv_host_chk.sv
module conv_host_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cs_tied,
    input logic upd_tick,
    input logic busy,
    input logic done,
    input logic reconfig_req,
    input logic late_read,
    input logic sclk,
    input logic cs_n,
    input logic sdo,
    input logic sdo_oe,
    input logic shared_mode
);

    a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    a_r1_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sdo != $past(sdo))) |-> $fell(sclk));

    a_r5_separate_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_mode |-> sdo_oe);

    a_r5_shared_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_mode && !busy) |-> !sdo_oe);

    a_r8_flag_rises_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reconfig_req) |-> done);

    a_r9_tied_select_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_tied |=> !cs_n);

    a_r10_late_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        late_read |-> ($past(upd_tick) && $past(busy)));

    a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r11_accept_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

endmodule

bind conv_host conv_host_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cs_tied      (cs_tied),
    .upd_tick     (upd_tick),
    .busy         (busy),
    .done         (done),
    .reconfig_req (reconfig_req),
    .late_read    (late_read),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .sdo          (sdo),
    .sdo_oe       (sdo_oe),
    .shared_mode  (shared_mode)
);

// File: tb/test_conv_host.sv
module test_conv_host;

    localparam int DIVW = 4;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  len;
        logic        sh;
        logic [3:0]  div;
        logic [7:0]  cmd;
        logic [23:0] wd;
        logic [23:0] pat;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 2'd1, 1'b0, 4'd0, 8'h10, 24'h0000A5, 24'h000000},
        '{2'd0, 2'd3, 1'b1, 4'd1, 8'h20, 24'h123456, 24'h000000},
        '{2'd1, 2'd2, 1'b0, 4'd0, 8'h38, 24'h000000, 24'hC35A00},
        '{2'd1, 2'd3, 1'b1, 4'd2, 8'h58, 24'h000000, 24'h9ABCDE},
        '{2'd2, 2'd0, 1'b0, 4'd0, 8'h08, 24'h000000, 24'h7F0000},
        '{2'd2, 2'd3, 1'b1, 4'd3, 8'h08, 24'h000000, 24'h800000},
        '{2'd0, 2'd0, 1'b0, 4'd1, 8'h11, 24'hABCD3C, 24'h000000},
        '{2'd3, 2'd0, 1'b0, 4'd0, 8'h00, 24'h000000, 24'h000000},
        '{2'd3, 2'd0, 1'b1, 4'd1, 8'h00, 24'h000000, 24'hF0F0F0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [1:0]  cmd_len = 2'd1;
    logic [23:0] wr_data = '0;
    logic [3:0]  div_half = '0;
    logic        shared_line = 1'b0;
    logic        cs_tied = 1'b0;
    logic        cs_sel = 1'b0;
    logic        upd_tick = 1'b0;
    logic        sdi;
    logic        busy, done, conv_ready, reconfig_req, late_read, sclk, cs_n, sdo, sdo_oe;
    logic [23:0] rd_data;

    logic        slave_en = 1'b0;
    logic        sbit = 1'b1;
    logic [23:0] pat_cur = '0;
    logic        prev_sclk = 1'b1;
    logic        prev_line = 1'b1;
    logic        prev_oe = 1'b1;
    logic [63:0] stream = '0;
    int          rises = 0;
    int          oelow = 0;
    int          lowrun = 0;
    int          lowlen = 0;
    logic        done_seen = 1'b0;
    logic        late_seen = 1'b0;
    int          checks = 0;
    int          failures = 0;
    int          wd_cnt = 0;

    always #10 clk = ~clk;

    assign sdi = shared_line ? (sdo_oe ? sdo : (slave_en ? sbit : 1'b1))
                             : (slave_en ? sbit : 1'b1);

    conv_host #(.DIVW(DIVW)) i_conv_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_byte     (cmd_byte),
        .cmd_len      (cmd_len),
        .wr_data      (wr_data),
        .div_half     (div_half),
        .shared_line  (shared_line),
        .cs_tied      (cs_tied),
        .cs_sel       (cs_sel),
        .upd_tick     (upd_tick),
        .sdi          (sdi),
        .busy         (busy),
        .done         (done),
        .rd_data      (rd_data),
        .conv_ready   (conv_ready),
        .reconfig_req (reconfig_req),
        .late_read    (late_read),
        .sclk         (sclk),
        .cs_n         (cs_n),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe)
    );

    always @(posedge clk) begin
        wd_cnt <= wd_cnt + 1;
        if (wd_cnt == 150000) begin
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
            $finish;
        end
    end

    function automatic logic line_now();
        if (shared_line) return sdo_oe ? sdo : (slave_en ? sbit : 1'b1);
        return sdo;
    endfunction

    function automatic int eff_n(vec_t v);
        if (v.op == 2'd2 || v.len == 2'd0) return 1;
        return int'(v.len);
    endfunction

    function automatic int exp_len(vec_t v);
        if (v.op == 2'd3) return v.sh ? 56 : 32;
        return 8 + 8 * eff_n(v);
    endfunction

    function automatic int exp_oelow(vec_t v);
        if (!v.sh) return 0;
        if (v.op == 2'd1 || v.op == 2'd2) return 8 * eff_n(v);
        if (v.op == 2'd3) return 24;
        return 0;
    endfunction

    function automatic logic exp_bit(vec_t v, int i);
        int  n = eff_n(v);
        logic host = !v.sh || v.op == 2'd0 ||
                     ((v.op == 2'd1 || v.op == 2'd2) && i <= 8) ||
                     (v.op == 2'd3 && i > 24);
        if (host) begin
            if (v.op == 2'd3) return 1'b1;
            if (i <= 8) return v.cmd[8 - i];
            if (v.op == 2'd0) return v.wd[8 * n - 1 - (i - 9)];
            return 1'b1;
        end
        if (i > 8 && (i - 9) < 24) return v.pat[23 - (i - 9)];
        return 1'b1;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (done) done_seen = 1'b1;
        if (late_read) late_seen = 1'b1;
        if (sclk && !prev_sclk) begin
            rises++;
            stream = {stream[62:0], prev_line};
            if (!prev_oe) oelow++;
            lowlen = lowrun;
        end
        if (!sclk) lowrun++;
        else lowrun = 0;
        if (!sclk && prev_sclk && rises >= 8) begin
            slave_en = 1'b1;
            sbit = ((rises - 8) < 24) ? pat_cur[23 - (rises - 8)] : 1'b1;
        end
        prev_sclk = sclk;
        prev_oe   = sdo_oe;
        prev_line = line_now();
    endtask

    task automatic issue(input vec_t v);
        cmd_op      = v.op;
        cmd_len     = v.len;
        cmd_byte    = v.cmd;
        wr_data     = v.wd;
        div_half    = v.div;
        shared_line = v.sh;
        pat_cur     = v.pat;
        slave_en    = 1'b0;
        sbit        = 1'b1;
        stream      = '0;
        rises       = 0;
        oelow       = 0;
        done_seen   = 1'b0;
        late_seen   = 1'b0;
        cmd_valid   = 1'b1;
        step();
        cmd_valid   = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 4000 && !done_seen; k++) step();
    endtask

    initial begin
        vec_t v;
        logic [63:0] exp_s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // Reset state
        chk(sclk == 1'b1 && busy == 1'b0, "R1 reset idle", {sclk, busy}, 2'b10);
        chk(reconfig_req == 1'b0 && late_read == 1'b0 && done == 1'b0, "R8 reset flags",
            {reconfig_req, late_read, done}, 0);
        chk(sdo == 1'b1 && sdo_oe == 1'b1, "R5 reset separate enable", {sdo, sdo_oe}, 2'b11);

        // Vector table
        for (int vi = 0; vi < NVEC; vi++) begin
            v = VECS[vi];
            issue(v);
            wait_done();
            chk(done_seen, "R11 done seen", done_seen, 1);
            chk(busy == 1'b0 && sclk == 1'b1, "R1 idle high after command", {busy, sclk}, 2'b01);
            chk(rises == exp_len(v), "R2 R3 R6 R7 clock count", rises, exp_len(v));
            exp_s = '0;
            for (int i = 1; i <= exp_len(v); i++) exp_s = {exp_s[62:0], exp_bit(v, i)};
            chk(stream == exp_s, "R2 R3 R6 R7 line bit stream", stream, exp_s);
            chk(oelow == exp_oelow(v), "R5 R7 enable low clocks", oelow, exp_oelow(v));
            chk(lowlen == int'(v.div) + 1, "R1 half period", lowlen, int'(v.div) + 1);
            if (v.op == 2'd1)
                chk(rd_data == (v.pat >> (24 - 8 * eff_n(v))), "R3 read data", rd_data,
                    v.pat >> (24 - 8 * eff_n(v)));
            if (v.op == 2'd2) begin
                chk(rd_data == {16'h0, v.pat[23:16]}, "R4 poll byte", rd_data, v.pat[23:16]);
                chk(conv_ready == !v.pat[23], "R4 ready from bit 7", conv_ready, !v.pat[23]);
            end
            if (v.op == 2'd3)
                chk(reconfig_req == 1'b1, "R8 flag after recovery", reconfig_req, 1);
            if (v.sh) begin
                step();
                chk(sdo_oe == 1'b0, "R5 shared idle released", sdo_oe, 0);
            end
        end

        // R8: read keeps the flag, write clears it
        issue('{2'd1, 2'd1, 1'b0, 4'd0, 8'h38, 24'h0, 24'h550000});
        wait_done();
        chk(reconfig_req == 1'b1, "R8 read keeps flag", reconfig_req, 1);
        issue('{2'd0, 2'd1, 1'b0, 4'd0, 8'h10, 24'h000001, 24'h0});
        chk(reconfig_req == 1'b0, "R8 write clears flag", reconfig_req, 0);
        wait_done();

        // R11: command while busy is ignored
        issue('{2'd0, 2'd1, 1'b0, 4'd0, 8'h10, 24'h00005A, 24'h0});
        step();
        cmd_op = 2'd3;
        cmd_valid = 1'b1;
        step();
        cmd_valid = 1'b0;
        wait_done();
        repeat (10) step();
        chk(rises == 16 && busy == 1'b0, "R11 busy command ignored", rises, 16);
        chk(reconfig_req == 1'b0, "R11 no recovery from ignored command", reconfig_req, 0);

        // R10: update tick during a read
        issue('{2'd1, 2'd3, 1'b0, 4'd3, 8'h38, 24'h0, 24'h123456});
        repeat (10) step();
        upd_tick = 1'b1;
        step();
        upd_tick = 1'b0;
        wait_done();
        chk(late_seen, "R10 late read flagged", late_seen, 1);
        late_seen = 1'b0;
        upd_tick = 1'b1;
        step();
        upd_tick = 1'b0;
        step();
        step();
        chk(!late_seen, "R10 idle tick no flag", late_seen, 0);
        issue('{2'd0, 2'd2, 1'b0, 4'd1, 8'h10, 24'h00BEEF, 24'h0});
        repeat (6) step();
        upd_tick = 1'b1;
        step();
        upd_tick = 1'b0;
        wait_done();
        chk(!late_seen, "R10 write tick no flag", late_seen, 0);

        // R9: chip select
        cs_sel = 1'b1;
        step();
        step();
        chk(cs_n == 1'b0, "R9 select follows bit", cs_n, 0);
        cs_sel = 1'b0;
        step();
        step();
        chk(cs_n == 1'b1, "R9 deselect follows bit", cs_n, 1);
        cs_tied = 1'b1;
        step();
        step();
        chk(cs_n == 1'b0, "R9 tied low", cs_n, 0);
        cs_tied = 1'b0;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule